// File: doc/BRIEF.md
# Four-Phase Charge Pump Sequencer

This block is the digital controller of a regulated dual charge pump that builds a positive and a negative rail of equal magnitude from one supply. A free-running oscillator supplies a one-cycle tick. Each tick moves the sequencer one step through four pumping phases. Between any two phases there is one tick interval with every switch open. The phases run in a fixed order: store charge for the negative rail, transfer it to the negative rail, store charge for the positive rail, transfer it to the positive rail, and then wrap around.

Two comparator flags report that each rail has reached its magnitude target. The flags enter through a synchroniser. While both flags are high, the sequencer holds in the all-open state at a phase boundary. When either flag drops, it resumes with the phase that follows the last one it ran. A shutdown request opens every switch and holds them open. After release, pumping restarts from the first phase.

The outputs are a nine-bit switch-enable vector, a one-hot flag for the active phase, and the index of the current or most recent phase. All outputs are registered.

Top module: `cpump_seq`

## Requirements
- R1: Phases are entered in the order index 0 (negative store), 1 (negative transfer), 2 (positive store), 3 (positive transfer), then 0 again. While a phase is active, `phase_oh` has exactly bit `phase_idx` set. While no phase is active, `phase_oh` is zero and `phase_idx` keeps the last phase run.
- R2: Switch bits are: 0 flying-cap-1 top to supply, 1 flying-cap-1 top to ground, 2 flying-cap-1 bottom to ground, 3 flying-cap-1 bottom to flying-cap-2 bottom, 4 flying-cap-2 top to supply, 5 flying-cap-2 top to ground, 6 flying-cap-2 top to positive store, 7 flying-cap-2 bottom to ground, 8 flying-cap-2 bottom to negative store. The store phases close bits {1,3,4} (0x01A). Negative transfer closes {0,2,5,8} (0x125). Positive transfer closes {0,2,6,7} (0x0C5).
- R3: Phases 0 and 2 drive the same switch pattern.
- R4: A phase lasts from one tick to the next. The following tick interval has every switch open. A nonzero pattern is only ever entered from the all-open state.
- R5: Bits 0 and 1 are never both set, and bits 4 and 5 are never both set.
- R6: On a tick in the open state, a new phase starts when at least one synchronised rail flag is low. No phase starts while both are high.
- R7: After a regulation hold, pumping resumes with the phase after the last one run.
- R8: Two clock edges after `shdn_req` is sampled high, all switches are open and `phase_idx` is 3. Ticks have no effect while `shdn_req` is high. The first phase after release is index 0.
- R9: Each rail flag passes through a two-stage synchroniser. A flag change that arrives at the same edge as a tick does not affect that tick.
- R10: After reset, all switches are open, `phase_oh` is 0, `phase_idx` is 3, and the first phase run is index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle oscillator step pulse |
| shdn_req | input | 1 | Shutdown request, active high |
| pos_rail_ok | input | 1 | Positive rail at target (asynchronous) |
| neg_rail_ok | input | 1 | Negative rail at target (asynchronous) |
| sw_en | output | 9 | Switch enables, bit map in R2 |
| phase_oh | output | 4 | One-hot active phase |
| phase_idx | output | 2 | Current or last phase index |

## Verification
The main sequence is driven with a long run of ticks and both flags low. This separates errors in phase order, pattern decode and the open gap between phases. A run with only one flag high shows that one unmet rail is enough to keep pumping. A run with both flags high, followed by one flag dropping, shows both the hold and the resume point. A shutdown asserted in the middle of a phase, followed by ticks and then release, tells the restart-from-zero rule apart from a plain resume. A flag that changes at the same edge as a tick exposes any missing synchroniser stage.

// File: rtl/cp_pkg.sv
package cp_pkg;
  localparam int NSW = 9;
  localparam int NPH = 4;

  typedef enum logic [1:0] {
    PH_NSTORE = 2'd0,
    PH_NXFER  = 2'd1,
    PH_PSTORE = 2'd2,
    PH_PXFER  = 2'd3
  } phase_e;

  localparam int SW_F1T_SUP = 0;
  localparam int SW_F1T_GND = 1;
  localparam int SW_F1B_GND = 2;
  localparam int SW_F1B_F2B = 3;
  localparam int SW_F2T_SUP = 4;
  localparam int SW_F2T_GND = 5;
  localparam int SW_F2T_POS = 6;
  localparam int SW_F2B_GND = 7;
  localparam int SW_F2B_NEG = 8;

  function automatic logic [NSW-1:0] sw_pattern(input phase_e p);
    logic [NSW-1:0] m;
    m = '0;
    case (p)
      PH_NSTORE, PH_PSTORE: begin
        m[SW_F1T_GND] = 1'b1;
        m[SW_F1B_F2B] = 1'b1;
        m[SW_F2T_SUP] = 1'b1;
      end
      PH_NXFER: begin
        m[SW_F1T_SUP] = 1'b1;
        m[SW_F1B_GND] = 1'b1;
        m[SW_F2T_GND] = 1'b1;
        m[SW_F2B_NEG] = 1'b1;
      end
      default: begin
        m[SW_F1T_SUP] = 1'b1;
        m[SW_F1B_GND] = 1'b1;
        m[SW_F2T_POS] = 1'b1;
        m[SW_F2B_GND] = 1'b1;
      end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cp_phase_fsm.sv
module cp_phase_fsm
  import cp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   sd,
  input  logic   pos_ok,
  input  logic   neg_ok,
  output logic   active,
  output phase_e idx
);
  logic   active_q, nxt_active;
  phase_e idx_q, nxt_idx;
  logic   demand;

  assign demand = !(pos_ok && neg_ok);

  always_comb begin
    nxt_active = active_q;
    nxt_idx    = idx_q;
    if (sd) begin
      nxt_active = 1'b0;
      nxt_idx    = PH_PXFER;
    end else if (tick) begin
      if (active_q) begin
        nxt_active = 1'b0;
      end else if (demand) begin
        nxt_active = 1'b1;
        nxt_idx    = phase_e'(idx_q + 2'd1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= PH_PXFER;
    end else begin
      active_q <= nxt_active;
      idx_q    <= nxt_idx;
    end
  end

  assign active = active_q;
  assign idx    = idx_q;

  // R1
  order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> (idx_q == phase_e'($past(idx_q) + 2'd1)));

  // R8
  shdn_chk: assert property (@(posedge clk) disable iff (rst)
    sd |=> (!active_q && idx_q == PH_PXFER));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_q && pos_ok && neg_ok && !sd) |=> !active_q);

  // R4
  dwell_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && !tick && !sd) |=> (active_q && $stable(idx_q)));
endmodule

// File: rtl/cp_switch_map.sv
module cp_switch_map
  import cp_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           active,
  input  phase_e         idx,
  output logic [NSW-1:0] sw_q,
  output logic [NPH-1:0] oh_q,
  output logic [1:0]     idx_q
);
  logic [NSW-1:0] sw_d;
  logic [NPH-1:0] oh_d;

  assign sw_d = active ? sw_pattern(idx) : '0;

  for (genvar p = 0; p < NPH; p++) begin : g_oh
    assign oh_d[p] = active && (int'(idx) == p);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q  <= '0;
      oh_q  <= '0;
      idx_q <= 2'd3;
    end else begin
      sw_q  <= sw_d;
      oh_q  <= oh_d;
      idx_q <= idx;
    end
  end

  // R5
  f1_short_chk: assert property (@(posedge clk) disable iff (rst)
    !(sw_q[SW_F1T_SUP] && sw_q[SW_F1T_GND]));

  // R5
  f2_short_chk: assert property (@(posedge clk) disable iff (rst)
    !(sw_q[SW_F2T_SUP] && sw_q[SW_F2T_GND]));

  // R4
  bbm_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_q != '0 && sw_q != $past(sw_q)) |-> ($past(sw_q) == '0));

  // R1
  onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oh_q) && ((sw_q != '0) == (oh_q != '0)));
endmodule

// File: rtl/cpump_seq.sv
module cpump_seq
  import cp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           osc_tick,
  input  logic           shdn_req,
  input  logic           pos_rail_ok,
  input  logic           neg_rail_ok,
  output logic [NSW-1:0] sw_en,
  output logic [NPH-1:0] phase_oh,
  output logic [1:0]     phase_idx
);
  logic [1:0] ok_sync;
  logic       act;
  phase_e     cur;

  // R9
  cp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pos_rail_ok, neg_rail_ok}),
    .q   (ok_sync)
  );

  cp_phase_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .tick   (osc_tick),
    .sd     (shdn_req),
    .pos_ok (ok_sync[1]),
    .neg_ok (ok_sync[0]),
    .active (act),
    .idx    (cur)
  );

  cp_switch_map u_map (
    .clk    (clk),
    .rst    (rst),
    .active (act),
    .idx    (cur),
    .sw_q   (sw_en),
    .oh_q   (phase_oh),
    .idx_q  (phase_idx)
  );
endmodule

// File: tb/cpump_seq_test.sv
module cpump_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 1'b0, shdn_req = 1'b0, pos_rail_ok = 1'b0, neg_rail_ok = 1'b0;
  logic [8:0] sw_en;
  logic [3:0] phase_oh;
  logic [1:0] phase_idx;

  always #10 clk = ~clk;

  cpump_seq uut (.*);

  typedef struct {
    logic [8:0] sw;
    logic [3:0] oh;
    logic [1:0] idx;
    string      tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int total = 0, bad = 0;
  bit done = 0;

  logic       m_act = 1'b0;
  logic [1:0] m_idx = 2'd3;
  logic       m_dem = 1'b1;

  function automatic logic [8:0] pat(input logic [1:0] i);
    case (i)
      2'd0, 2'd2: return 9'h01A;
      2'd1:       return 9'h125;
      default:    return 9'h0C5;
    endcase
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.sw  = m_act ? pat(m_idx) : 9'h000;
    e.oh  = m_act ? (4'b0001 << m_idx) : 4'b0000;
    e.idx = m_idx;
    e.tag = tag;
    q.push_back(e);
    ->chk_ev;
  endtask

  task automatic step_model;
    if (!shdn_req) begin
      if (m_act) m_act = 1'b0;
      else if (m_dem) begin m_act = 1'b1; m_idx = m_idx + 2'd1; end
    end
  endtask

  task automatic do_tick(input string tag);
    step_model();
    @(negedge clk) osc_tick = 1'b1;
    @(negedge clk) osc_tick = 1'b0;
    repeat (3) @(negedge clk);
    push(tag);
  endtask

  task automatic set_flags(input logic p, input logic n);
    @(negedge clk);
    pos_rail_ok = p;
    neg_rail_ok = n;
    m_dem = !(p && n);
    repeat (4) @(negedge clk);
  endtask

  always begin
    @(chk_ev);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (sw_en !== e.sw || phase_oh !== e.oh || phase_idx !== e.idx) begin
        bad++;
        $display("FAIL %s: sw=%h oh=%b idx=%0d expected sw=%h oh=%b idx=%0d",
                 e.tag, sw_en, phase_oh, phase_idx, e.sw, e.oh, e.idx);
      end
      total++;
      if ((sw_en[0] && sw_en[1]) || (sw_en[4] && sw_en[5])) begin
        bad++;
        $display("FAIL R5: sw=%h expected no supply/ground pair", sw_en);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    push("R10 reset");

    // R1 R2 R3 R4: full cycle, flags low
    for (int i = 0; i < 8; i++) do_tick("R1/R2/R3/R4 cycle");

    // R6: one rail unmet keeps pumping
    set_flags(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) do_tick("R6 one flag");

    // R6: both met holds at boundary
    set_flags(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) do_tick("R6 hold");

    // R7: resume with next phase
    set_flags(1'b0, 1'b1);
    do_tick("R7 resume");
    do_tick("R7 gap");
    do_tick("R7 next");

    // R8: shutdown mid-phase
    @(negedge clk) shdn_req = 1'b1;
    m_act = 1'b0;
    m_idx = 2'd3;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    push("R8 open");
    do_tick("R8 tick ignored");
    do_tick("R8 tick ignored");
    @(negedge clk) shdn_req = 1'b0;
    do_tick("R8 restart");
    do_tick("R8 gap");

    // R9: flag change at the tick edge is not seen by that tick
    @(negedge clk);
    pos_rail_ok = 1'b1;
    neg_rail_ok = 1'b1;
    osc_tick = 1'b1;
    step_model();
    m_dem = 1'b0;
    @(negedge clk) osc_tick = 1'b0;
    repeat (3) @(negedge clk);
    push("R9 late flag");
    do_tick("R9 gap");
    do_tick("R9 hold");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule